// File: doc/BRIEF.md
# Payload Label Integrator and Checker

This block watches the payload label carried in the MA overhead byte of each received E3 frame (G.832 framing). A receiver pulses a strobe once per frame along with the MA byte. The block pulls the three-bit label out of that byte and filters it over frames. A label replaces the stored value only after it has been seen in several frames in a row, so a single corrupted frame cannot change it.

The block produces three indications from the stored label:
- a one-cycle pulse each time the stored label takes a new value;
- a flag that is high while the incoming label keeps moving and never persists long enough to be accepted;
- a flag that is high when the stored label disagrees with a label programmed as the expected one.

The MA byte input is a plain per-frame strobe with no back-pressure. The block takes a byte on every cycle the strobe is high and never stalls the sender. Cycles without the strobe leave all state as it is. The expected label is a static control input. The mismatch flag follows it in the same cycle.

Top module: `e3_plabel_filter`

## Requirements
- R1: After a synchronous active-low reset, the accepted label is 000 and the change, unstable and mismatch outputs are all low (with expected label 000).
- R2: The label of a frame is MA byte bits [5:3] of the input vector. These are the third, fourth and fifth bits counting from the most significant bit.
- R3: The accepted label takes a new value on the strobe that completes 5 consecutive strobes carrying that same label. After 4 such strobes it keeps its old value. It is visible the cycle after that strobe.
- R4: The change output is high for exactly one cycle, the cycle after the strobe that altered the accepted label. It stays low when a run of 5 only repeats the current accepted label.
- R5: Cycles with the strobe low change neither the label run, the accepted label nor the unstable state. A run therefore continues across idle gaps of any length.
- R6: The unstable output rises after 8 consecutive strobes in each of which the current label run is shorter than 5.
- R7: The unstable output falls, and its frame count restarts, on any strobe that completes a run of 5 or more equal labels. This holds whether or not that label differs from the accepted one.
- R8: With expected label 000, mismatch is high exactly when the accepted label is nonzero.
- R9: With expected label 001, mismatch is high exactly when the accepted label is 000.
- R10: With any other expected label, mismatch is high exactly when the accepted label differs from it. Mismatch responds combinationally to the expected label input.
- R11: MA byte bits [7:6] and [2:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ma_stb | input | 1 | One-cycle strobe per received frame: MA byte valid |
| ma_byte | input | 8 | Received MA byte |
| exp_label | input | 3 | Programmed expected payload label |
| acc_label | output | 3 | Accepted (integrated) payload label |
| label_chg | output | 1 | One-cycle pulse when the accepted label changes |
| label_unstable | output | 1 | Incoming label has not settled for 8 frames |
| label_mismatch | output | 1 | Accepted label disagrees with the expected label |

## Verification
The bench targets several corner cases, each of which exposes a particular mistake:
- **Four frames versus five.** The bench sends runs of exactly four and exactly five equal labels. An off-by-one in the run counter would accept early or one frame late.
- **Run broken by a single odd frame.** A design that forgot to restart its run here would accept a label that never persisted.
- **Idle gaps inside runs.** A design that treated silence as a broken run would never accept the label under sparse strobes.
- **Reconfirming the current label.** A run of five that only repeats the accepted label must clear the unstable flag without pulsing change. A design that keyed the clear to a change would leave the flag stuck.
- **Mismatch rules.** The bench sweeps the expected label across 000, 001 and specific values. It also toggles the MA bits outside the label field, which would expose a shifted bit slice.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
  localparam int LBL_W = 3;
  typedef logic [LBL_W-1:0] label_t;

  localparam label_t LBL_UNEQ  = 3'b000;
  localparam label_t LBL_EQUIP = 3'b001;

  // Label occupies the 3rd..5th bits from the MSB of the MA byte.
  function automatic label_t ma_to_label(input logic [7:0] ma);
    return ma[5:3];
  endfunction

  function automatic logic label_disagree(input label_t acc, input label_t exp_l);
    if (exp_l == LBL_UNEQ)       return (acc != LBL_UNEQ);
    else if (exp_l == LBL_EQUIP) return (acc == LBL_UNEQ);
    else                         return (acc != exp_l);
  endfunction
endpackage

// File: rtl/ptl_persist.sv
module ptl_persist
  import ptl_pkg::*;
#(
  parameter int ACCEPT_N = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stb,
  input  label_t lbl,
  output logic   hit
);
  localparam int RUN_W = $clog2(ACCEPT_N + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ACCEPT_N);

  label_t           cand_q;
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    if (lbl != cand_q)       run_d = RUN_W'(1);
    else if (run_q < RUN_MAX) run_d = run_q + RUN_W'(1);
    else                     run_d = run_q;
  end

  assign hit = stb && (run_d == RUN_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= '0;
      run_q  <= '0;
    end else if (stb) begin
      cand_q <= lbl;
      run_q  <= run_d;
    end
  end

  p_run_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(run_q) && $stable(cand_q));
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);
endmodule

// File: rtl/ptl_unsettle.sv
module ptl_unsettle #(
  parameter int UNSET_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic hit,
  output logic unstable
);
  localparam int CNT_W = $clog2(UNSET_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(UNSET_N);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (stb) begin
      if (hit)                 cnt_d = '0;
      else if (cnt_q < CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      unstable <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      unstable <= (cnt_d == CNT_MAX);
    end
  end

  p_clear_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb && hit |=> !unstable);
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(unstable));
endmodule

// File: rtl/e3_plabel_filter.sv
module e3_plabel_filter
  import ptl_pkg::*;
#(
  parameter int ACCEPT_N = 5,
  parameter int UNSET_N  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ma_stb,
  input  logic [7:0] ma_byte,
  input  logic [2:0] exp_label,
  output logic [2:0] acc_label,
  output logic       label_chg,
  output logic       label_unstable,
  output logic       label_mismatch
);
  label_t lbl;
  logic   hit;

  assign lbl = ma_to_label(ma_byte);

  ptl_persist #(.ACCEPT_N(ACCEPT_N)) u_persist (
    .clk(clk), .rst_n(rst_n), .stb(ma_stb), .lbl(lbl), .hit(hit)
  );

  ptl_unsettle #(.UNSET_N(UNSET_N)) u_unsettle (
    .clk(clk), .rst_n(rst_n), .stb(ma_stb), .hit(hit), .unstable(label_unstable)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_label <= LBL_UNEQ;
      label_chg <= 1'b0;
    end else begin
      label_chg <= hit && (lbl != acc_label);
      if (hit) acc_label <= lbl;
    end
  end

  assign label_mismatch = label_disagree(acc_label, exp_label);

  p_chg_needs_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    label_chg |-> $past(ma_stb));
  p_chg_new_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    label_chg |-> (acc_label != $past(acc_label)));
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ma_stb |=> $stable(acc_label));
  p_chg_clears_unstable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    label_chg |-> !label_unstable);
  always_comb begin
    if (exp_label == 3'b001)
      p_equip_rule_r9: assert (label_mismatch == (acc_label == 3'b000));
  end
endmodule

// File: tb/e3_plabel_filter_bench.sv
module e3_plabel_filter_bench;
  localparam int CLK_HALF = 5;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ma_stb = 0;
  logic [7:0] ma_byte = 0;
  logic [2:0] exp_label = 0;
  logic [2:0] acc_label;
  logic       label_chg, label_unstable, label_mismatch;

  int total = 0, bad = 0;

  e3_plabel_filter u_e3_plabel_filter (
    .clk(clk), .rst_n(rst_n), .ma_stb(ma_stb), .ma_byte(ma_byte),
    .exp_label(exp_label), .acc_label(acc_label), .label_chg(label_chg),
    .label_unstable(label_unstable), .label_mismatch(label_mismatch)
  );

  always #CLK_HALF clk = ~clk;

  // behavioural reference
  int m_acc = 0, m_cand = 0, m_run = 0, m_ucnt = 0;
  bit m_chg = 0, m_uns = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_cand = 0; m_run = 0; m_ucnt = 0; m_chg = 0; m_uns = 0;
    end else begin
      m_chg = 0;
      if (ma_stb) begin
        int l;
        l = (int'(ma_byte) >> 3) & 7;
        if (l == m_cand) m_run = (m_run < 5) ? m_run + 1 : 5;
        else begin m_cand = l; m_run = 1; end
        if (m_run >= 5) begin
          m_ucnt = 0; m_uns = 0;
          if (m_acc != l) begin m_acc = l; m_chg = 1; end
        end else begin
          if (m_ucnt < 8) m_ucnt++;
          if (m_ucnt >= 8) m_uns = 1;
        end
      end
    end
  end

  function automatic bit model_mis(int acc, int e);
    if (e == 0) return acc != 0;
    if (e == 1) return acc == 0;
    return acc != e;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // continuous comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(acc_label == m_acc[2:0], "R3 acc_label", acc_label, m_acc);
      chk(label_chg == m_chg, "R4 label_chg", label_chg, m_chg);
      chk(label_unstable == m_uns, "R6 label_unstable", label_unstable, m_uns);
      chk(label_mismatch == model_mis(m_acc, exp_label),
          exp_label == 0 ? "R8 mismatch" : exp_label == 1 ? "R9 mismatch" : "R10 mismatch",
          label_mismatch, model_mis(m_acc, exp_label));
    end
  end

  task automatic send(int lbl, int gap);
    @(negedge clk);
    ma_stb  = 1;
    ma_byte = 8'((lbl & 7) << 3) | 8'($urandom & 8'hC7);  // R11 junk outside field
    @(negedge clk);
    ma_stb = 0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(acc_label == 0, "R1 acc_label", acc_label, 0);
        chk(!label_chg && !label_unstable && !label_mismatch, "R1 flags",
            {label_chg, label_unstable, label_mismatch}, 0);
        // R3: four frames not enough
        repeat (4) send(5, 0);
        chk(acc_label == 0, "R3 after 4", acc_label, 0);
        // fifth, placed via explicit byte for R2 field position
        @(negedge clk); ma_stb = 1; ma_byte = 8'b11_101_111; @(negedge clk); ma_stb = 0;
        chk(acc_label == 5, "R2 R3 after 5", acc_label, 5);
        chk(label_chg == 1, "R4 pulse", label_chg, 1);
        @(negedge clk);
        chk(label_chg == 0, "R4 one cycle", label_chg, 0);
        // R5: run across long gaps
        for (int i = 0; i < 5; i++) send(3, 7);
        chk(acc_label == 3, "R5 gaps", acc_label, 3);
        // broken run
        repeat (4) send(6, 0); send(2, 0); repeat (4) send(6, 0);
        chk(acc_label == 3, "R3 broken run", acc_label, 3);
        // R6: keep changing
        for (int i = 0; i < 10; i++) send(i % 2 == 0 ? 4 : 7, i % 3);
        chk(label_unstable == 1, "R6 set", label_unstable, 1);
        // R7: reconfirm accepted label 3 without change
        repeat (4) send(3, 0);
        chk(label_unstable == 1, "R7 still set", label_unstable, 1);
        send(3, 0);
        chk(label_unstable == 0, "R7 cleared", label_unstable, 0);
        chk(acc_label == 3, "R7 no change", acc_label, 3);
        // mismatch sweep
        for (int e = 0; e < 8; e++) begin
          exp_label = 3'(e);
          #1;
          chk(label_mismatch == model_mis(3, e), "R10 sweep", label_mismatch, model_mis(3, e));
        end
        exp_label = 0;
        repeat (5) send(0, 1);
        chk(label_mismatch == 0, "R8 zero", label_mismatch, 0);
        exp_label = 1;
        #1 chk(label_mismatch == 1, "R9 zero", label_mismatch, 1);
        // random traffic
        for (int i = 0; i < 400; i++) begin
          exp_label = 3'($urandom);
          send(($urandom % 4 == 0) ? $urandom : 6, $urandom % 3);
        end
        // R1 reset mid-run
        repeat (3) send(2, 0);
        @(negedge clk); rst_n = 0; exp_label = 0; @(negedge clk); rst_n = 1; #1;
        chk(acc_label == 0 && !label_unstable && !label_mismatch, "R1 re-reset", acc_label, 0);
      end
      begin
        repeat (150000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule